// File: doc/BRIEF.md
# Sleep Timer Save/Restore Register

This block keeps the value of a radio link-layer fine counter across deep sleep. It sits in an always-on domain. When the link layer goes to sleep, the block captures the counter value. When the link layer wakes, it hands the held value back to the counter with a one-cycle valid strobe. While the link layer sleeps, software may read the held value and overwrite it through a small register port.

The port exposes two words. Word 0 is the hold register, whose 10-bit value sits in bits [9:0]. Word 1 is a control word, and only its read-source field in bits [6:5] is stored. That field decides what a read of word 0 returns:

- 0: the held value.
- 1: a deep-sleep duration.
- 2: the low 10 bits of a sampled sleep time.
- 3: a monitor flag placed above bits [18:10] of the sampled sleep time.

Software writes to word 0 always land in the held value, whatever the field says. A write is posted through one stage. A read in the very next cycle therefore still sees the old value, and a read-back needs one idle cycle between the write and the read.

Top module: `slptmr_hold`

## Requirements
- R1: After reset, `bus_rdata`, `restore_vld` and `restore_data` are 0, and reads of both words return 0.
- R2: A one-cycle `sleep_enter` pulse loads `fine_cnt` into the held value. With the read source at 0, a later read of word 0 (`bus_addr`=0) returns it in bits [9:0].
- R3: A one-cycle `wake` pulse makes `restore_vld` high for exactly the next cycle, with `restore_data` equal to the held value.
- R4: A write to word 0 updates the held value for every read-source setting. A read issued two or more cycles after the write returns the new value (read source 0).
- R5: A read of word 0 in the cycle directly after a write to word 0 returns the value held before that write.
- R6: Software writes never pulse `restore_vld` and never change `restore_data`.
- R7: A write to word 1 sets the read source from `bus_wdata[6:5]`. Reading word 1 returns that field in bits [6:5] and zeros elsewhere. Reads of word 0 then return, by source:
  - 0: the held value.
  - 1: `dsl_dur`.
  - 2: `dsl_time[9:0]`.
  - 3: `{dsl_mon, dsl_time[18:10]}`.
- R8: Bits [15:10] of every word-0 read are 0.
- R9: If `wake` and `sleep_enter` occur in the same cycle, the restore happens and the held value is not resampled.
- R10: If a hardware sample and a posted software write land in the same cycle, the sampled counter value wins.
- R11: `bus_rdata` changes only in the cycle after a read (`bus_rd` high), and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | Word select: 0 hold, 1 control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sleep_enter | input | 1 | Sleep-entry pulse, samples the counter |
| wake | input | 1 | Wake pulse, starts a restore |
| fine_cnt | input | 10 | Live fine-counter value |
| restore_data | output | 10 | Value pushed back into the counter |
| restore_vld | output | 1 | One-cycle restore strobe |
| dsl_dur | input | 10 | Deep-sleep duration diagnostic |
| dsl_time | input | 19 | Sampled deep-sleep time diagnostic |
| dsl_mon | input | 1 | Deep-sleep monitor status |

## Verification
Each result is due at a fixed number of edges after its stimulus:

- Read data and the restore strobe are due one edge after `bus_rd` or `wake`.
- A sample is visible to a read issued in the next cycle.
- A posted write becomes readable only by a read issued two cycles after it; a read one cycle after it still returns the old value.

Every task drives its inputs just after a rising edge and samples just after the edge at which the result is due. That lets the bench check both the stale read and the settled read-back at their exact cycles.

// File: rtl/slptmr_pkg.sv
package slptmr_pkg;
    localparam int DATA_W   = 16;
    localparam int HOLD_W   = 10;
    localparam int TIME_W   = 19;
    localparam int SRC_LSB  = 5;
    localparam int SRC_W    = 2;
    localparam int HI_W     = TIME_W - HOLD_W;

    typedef enum logic [SRC_W-1:0] {
        SRC_HELD = 2'd0,
        SRC_DUR  = 2'd1,
        SRC_TLO  = 2'd2,
        SRC_THI  = 2'd3
    } rd_src_e;
endpackage

// File: rtl/slptmr_post.sv
module slptmr_post
    import slptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hold,
    input  logic [HOLD_W-1:0] wdata,
    output logic              commit,
    output logic [HOLD_W-1:0] commit_data
);
    typedef struct packed {
        logic              vld;
        logic [HOLD_W-1:0] data;
    } post_t;

    post_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = wr_hold;
        if (wr_hold) begin
            st_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit      = st_q.vld;
    assign commit_data = st_q.data;
endmodule

// File: rtl/slptmr_store.sv
module slptmr_store
    import slptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_enter,
    input  logic              wake,
    input  logic [HOLD_W-1:0] fine_cnt,
    input  logic              commit,
    input  logic [HOLD_W-1:0] commit_data,
    output logic [HOLD_W-1:0] held,
    output logic              restore_vld,
    output logic [HOLD_W-1:0] restore_data
);
    typedef struct packed {
        logic [HOLD_W-1:0] held;
        logic              rvld;
        logic [HOLD_W-1:0] rdat;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rvld = 1'b0;
        if (wake) begin
            // restore wins over a coincident sample; held value kept
            st_d.rvld = 1'b1;
            st_d.rdat = st_q.held;
        end else if (sleep_enter) begin
            // hardware sample wins over a posted software write
            st_d.held = fine_cnt;
        end else if (commit) begin
            st_d.held = commit_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held         = st_q.held;
    assign restore_vld  = st_q.rvld;
    assign restore_data = st_q.rdat;
endmodule

// File: rtl/slptmr_rdsel.sv
module slptmr_rdsel
    import slptmr_pkg::*;
(
    input  rd_src_e           src,
    input  logic [HOLD_W-1:0] held,
    input  logic [HOLD_W-1:0] dsl_dur,
    input  logic [TIME_W-1:0] dsl_time,
    input  logic              dsl_mon,
    output logic [DATA_W-1:0] view
);
    logic [HOLD_W-1:0] pick;

    always_comb begin
        unique case (src)
            SRC_HELD: pick = held;
            SRC_DUR:  pick = dsl_dur;
            SRC_TLO:  pick = dsl_time[HOLD_W-1:0];
            SRC_THI:  pick = HOLD_W'({dsl_mon, dsl_time[TIME_W-1:HOLD_W]});
            default:  pick = held;
        endcase
        view = DATA_W'(pick);
    end
endmodule

// File: rtl/slptmr_hold.sv
module slptmr_hold
    import slptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sleep_enter,
    input  logic              wake,
    input  logic [HOLD_W-1:0] fine_cnt,
    output logic [HOLD_W-1:0] restore_data,
    output logic              restore_vld,
    input  logic [HOLD_W-1:0] dsl_dur,
    input  logic [TIME_W-1:0] dsl_time,
    input  logic              dsl_mon
);
    typedef struct packed {
        rd_src_e           src;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t st_d, st_q;

    logic              commit;
    logic [HOLD_W-1:0] commit_data;
    logic [HOLD_W-1:0] held;
    logic [DATA_W-1:0] hold_view;
    logic [DATA_W-1:0] ctrl_view;
    logic              unused_wbits;

    assign unused_wbits = ^{bus_wdata[DATA_W-1:HOLD_W]};

    slptmr_post u_post (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hold     (bus_wr && !bus_addr),
        .wdata       (bus_wdata[HOLD_W-1:0]),
        .commit      (commit),
        .commit_data (commit_data)
    );

    slptmr_store u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_enter  (sleep_enter),
        .wake         (wake),
        .fine_cnt     (fine_cnt),
        .commit       (commit),
        .commit_data  (commit_data),
        .held         (held),
        .restore_vld  (restore_vld),
        .restore_data (restore_data)
    );

    slptmr_rdsel u_rdsel (
        .src      (st_q.src),
        .held     (held),
        .dsl_dur  (dsl_dur),
        .dsl_time (dsl_time),
        .dsl_mon  (dsl_mon),
        .view     (hold_view)
    );

    always_comb begin
        ctrl_view = '0;
        ctrl_view[SRC_LSB +: SRC_W] = st_q.src;
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr) begin
            st_d.src = rd_src_e'(bus_wdata[SRC_LSB +: SRC_W]);
        end
        if (bus_rd) begin
            st_d.rdata = bus_addr ? ctrl_view : hold_view;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{src: SRC_HELD, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/slptmr_hold_chk.sv
module slptmr_hold_chk
    import slptmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_addr,
    input logic              wake,
    input logic              restore_vld,
    input logic [HOLD_W-1:0] restore_data,
    input logic [DATA_W-1:0] bus_rdata
);
    // R3
    restore_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (restore_vld == $past(wake)));

    // R6
    restore_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !restore_vld) |-> $stable(restore_data));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_rd)) |-> $stable(bus_rdata));

    // R8
    hold_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_rd) && !$past(bus_addr)) |-> (bus_rdata[DATA_W-1:HOLD_W] == '0));

    // R7
    ctrl_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_rd) && $past(bus_addr)) |->
        (bus_rdata[DATA_W-1:SRC_LSB+SRC_W] == '0 && bus_rdata[SRC_LSB-1:0] == '0));
endmodule

bind slptmr_hold slptmr_hold_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .wake         (wake),
    .restore_vld  (restore_vld),
    .restore_data (restore_data),
    .bus_rdata    (bus_rdata)
);

// File: tb/sim_slptmr_hold.sv
`timescale 1ns/1ps
module sim_slptmr_hold;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sleep_enter = 1'b0;
    logic        wake = 1'b0;
    logic [9:0]  fine_cnt = '0;
    logic [9:0]  restore_data;
    logic        restore_vld;
    logic [9:0]  dsl_dur = '0;
    logic [18:0] dsl_time = '0;
    logic        dsl_mon = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    slptmr_hold u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sleep_enter(sleep_enter), .wake(wake), .fine_cnt(fine_cnt),
        .restore_data(restore_data), .restore_vld(restore_vld),
        .dsl_dur(dsl_dur), .dsl_time(dsl_time), .dsl_mon(dsl_mon)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic bwrite(logic a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic bread(logic a);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic pulse_sleep(logic [9:0] v);
        fine_cnt = v; sleep_enter = 1'b1;
        tick();
        sleep_enter = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rdata", bus_rdata, 16'h0);
        check("R1 restore_vld", 16'(restore_vld), 16'h0);
        check("R1 restore_data", 16'(restore_data), 16'h0);
        bread(1'b0);
        check("R1 hold read", bus_rdata, 16'h0);
        bread(1'b1);
        check("R1 ctrl read", bus_rdata, 16'h0);
    endtask

    task automatic t_sample();
        pulse_sleep(10'h2A5);
        bread(1'b0);
        check("R2 sampled value", bus_rdata, 16'h02A5);
        check("R8 upper zero", 16'(bus_rdata[15:10]), 16'h0);
    endtask

    task automatic t_restore();
        wake = 1'b1;
        tick();
        wake = 1'b0;
        check("R3 restore_vld high", 16'(restore_vld), 16'h1);
        check("R3 restore_data", 16'(restore_data), 16'h2A5);
        tick();
        check("R3 restore_vld drop", 16'(restore_vld), 16'h0);
    endtask

    task automatic t_write_awake();
        bwrite(1'b0, 16'hFD55);
        check("R6 no strobe on write", 16'(restore_vld), 16'h0);
        tick();
        check("R6 no strobe after commit", 16'(restore_vld), 16'h0);
        check("R6 restore_data kept", 16'(restore_data), 16'h2A5);
        bread(1'b0);
        check("R4 read-back", bus_rdata, 16'h0155);
    endtask

    task automatic t_stale();
        bwrite(1'b0, 16'h00F0);
        bread(1'b0);
        check("R5 stale read", bus_rdata, 16'h0155);
        bread(1'b0);
        check("R4 settled read", bus_rdata, 16'h00F0);
    endtask

    task automatic t_modes();
        dsl_dur = 10'h3C3; dsl_time = 19'h5AB3C; dsl_mon = 1'b1;
        bwrite(1'b1, 16'(1) << 5);
        bread(1'b1);
        check("R7 ctrl readback", bus_rdata, 16'h0020);
        bread(1'b0);
        check("R7 source 1", bus_rdata, 16'(dsl_dur));
        bwrite(1'b1, 16'(2) << 5);
        bread(1'b0);
        check("R7 source 2", bus_rdata, 16'(dsl_time[9:0]));
        bwrite(1'b1, 16'hFFFF);
        bread(1'b1);
        check("R7 ctrl only field", bus_rdata, 16'h0060);
        bread(1'b0);
        check("R7 source 3", bus_rdata, 16'({dsl_mon, dsl_time[18:10]}));
        check("R8 upper zero source 3", 16'(bus_rdata[15:10]), 16'h0);
        bwrite(1'b0, 16'h0111);
        bwrite(1'b1, 16'h0000);
        bread(1'b0);
        check("R4 write in source 3", bus_rdata, 16'h0111);
    endtask

    task automatic t_collide();
        fine_cnt = 10'h3FE; sleep_enter = 1'b1; wake = 1'b1;
        tick();
        sleep_enter = 1'b0; wake = 1'b0;
        check("R9 restore strobe", 16'(restore_vld), 16'h1);
        check("R9 restore value", 16'(restore_data), 16'h111);
        bread(1'b0);
        check("R9 held unchanged", bus_rdata, 16'h0111);
    endtask

    task automatic t_hw_over_sw();
        bwrite(1'b0, 16'h00AA);
        pulse_sleep(10'h300);
        tick();
        bread(1'b0);
        check("R10 sample wins", bus_rdata, 16'h0300);
    endtask

    task automatic t_rdata_hold();
        pulse_sleep(10'h07E);
        bwrite(1'b1, 16'h0040);
        tick();
        tick();
        check("R11 rdata unchanged without read", bus_rdata, 16'h0300);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sample();
        t_restore();
        t_write_awake();
        t_stale();
        t_modes();
        t_collide();
        t_hw_over_sw();
        t_rdata_hold();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule